// File: doc/BRIEF.md
# Serial Transceiver with Loopback and Single-Wire Routing

This block is an asynchronous serial transceiver: one transmitter, one receiver and a shared baud-tick generator. The generator divides the clock by a 13-bit divisor and emits one tick per divisor period. Every bit on the line spans sixteen ticks. A routing stage sits between the two halves and the pads. It picks the receiver's source from three choices: the dedicated receive pin, the transmitter's own output, or the transmit pad when that pad is shared as a single half-duplex wire.

Software-facing registers are outside this block. Configuration arrives as plain inputs. Words to send are offered with a valid/ready handshake. Each received word is presented with a one-cycle strobe and a framing-error flag. A wait input, gated by a configuration bit, freezes all internal progress while the surrounding system is idle.

Top module: `sio_xcvr`

## Requirements
- R1: After reset the transmit pad output is high, `tx_ready` is 1, `rx_valid` is 0, and `txd_oe` is 1 in two-pin mode. Whenever the transmitter is idle, `txd_o` is 1.
- R2: For a divisor D in 1..8191, each data bit after the start bit lasts exactly 16×D clock cycles on `txd_o`.
- R3: With divisor 0 no ticks are produced. `tx_ready` stays 0, `txd_o` does not change, and no word is received. A word offered meanwhile is sent once a nonzero divisor is applied.
- R4: With `cfg_loop`=0 the receiver decodes frames from `rxd_i`. The transmitter's frames are not received.
- R5: With `cfg_loop`=1 and `cfg_rsel`=0 the transmitter output feeds the receiver internally. The level on `rxd_i` has no effect.
- R6: With `cfg_loop`=1 and `cfg_rsel`=1 the receiver reads `txd_pin_i` and ignores `rxd_i`. `txd_oe` is 1 only while a frame is being sent, so an external device can drive the shared wire at other times.
- R7: While `cfg_loop`=0, `cfg_rsel` has no effect: reception stays on `rxd_i` and `txd_oe` stays 1.
- R8: With `cfg_nine`=0 a transmitted frame is one low start bit, then data bits 0..7 least significant first, then one high stop bit.
- R9: With `cfg_nine`=1 data bit 8 follows bit 7 before the stop bit. All nine bits arrive at `rx_data`.
- R10: While `cfg_wfrz`=1 and `wait_i`=1, nothing advances: `txd_o` holds and no word is received. When the wait ends, the frame completes intact. With `cfg_wfrz`=0, `wait_i` has no effect.
- R11: A frame whose stop bit samples low is delivered with `rx_ferr`=1. A frame with a high stop bit is delivered with `rx_ferr`=0.
- R12: `rx_valid` is a single-cycle pulse. In 8-bit mode `rx_data[8]` is 0.
- R13: A word is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until that frame's stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 13 | Baud divisor; 0 stops the tick generator |
| cfg_loop | input | 1 | 1 routes the receiver away from `rxd_i` |
| cfg_rsel | input | 1 | With `cfg_loop`=1: 0 internal loop, 1 shared single wire |
| cfg_nine | input | 1 | 1 selects 9 data bits per frame |
| cfg_wfrz | input | 1 | 1 lets `wait_i` freeze the block |
| wait_i | input | 1 | System wait indication |
| tx_data | input | 9 | Word to send (bit 8 used only in 9-bit mode) |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a word this cycle |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| rx_ferr | output | 1 | Stop bit of the last word sampled low |
| rxd_i | input | 1 | Dedicated receive pin |
| txd_pin_i | input | 1 | Level sensed on the transmit pad |
| txd_o | output | 1 | Transmit pad drive value |
| txd_oe | output | 1 | Transmit pad output enable |

## Verification
On every cycle the assertions check the properties that can be stated locally. These are: the pad enable follows the routing mode, an idle transmitter marks high, the ready signal drops after a handshake, and the receive strobe never lasts two cycles. They also confirm that a zero divisor or an active freeze stops both the line and the receive strobe, and that bit 8 is clear in 8-bit mode. Only the bench's scenarios can show the end-to-end behaviour. That covers the exact bit period for several divisors, the bit order on the wire, the data recovered through each of the three routes (including that the unused pin is really ignored), resumption after a freeze, and framing-error reporting.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned OSR    = 16;
  localparam int unsigned OSR_W  = $clog2(OSR);
  localparam int unsigned DATA_W = 9;
  localparam int unsigned IDX_W  = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    RT_NORMAL = 2'd0,
    RT_LOOP   = 2'd1,
    RT_SINGLE = 2'd2
  } route_e;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             gen_on, wrap;

  assign gen_on = (div != '0);
  assign wrap   = (cnt_q >= (div - ONE));
  assign tick   = gen_on & run & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!gen_on) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = wrap ? '0 : (cnt_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              can_start,
  input  logic              tick,
  input  logic              nine,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line,
  output logic              busy
);
  localparam logic [OSR_W-1:0] SUB_LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0] SUB_ONE  = OSR_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST9    = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST8    = IDX_W'(DATA_W - 2);

  phase_e             ph_q, ph_d;
  logic [OSR_W-1:0]   sub_q, sub_d;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_last;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               nine_q, nine_d;
  logic               line_q, line_d;

  assign in_ready = (ph_q == PH_IDLE) & can_start;
  assign busy     = (ph_q != PH_IDLE);
  assign line     = line_q;
  assign idx_last = nine_q ? LAST9 : LAST8;

  always_comb begin
    ph_d   = ph_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    nine_d = nine_q;
    case (ph_q)
      PH_IDLE: begin
        if (in_valid && in_ready) begin
          ph_d   = PH_START;
          sub_d  = '0;
          idx_d  = '0;
          sh_d   = in_data;
          nine_d = nine;
        end
      end
      PH_START: begin
        if (tick) begin
          sub_d = sub_q + SUB_ONE;
          if (sub_q == SUB_LAST) ph_d = PH_DATA;
        end
      end
      PH_DATA: begin
        if (tick) begin
          sub_d = sub_q + SUB_ONE;
          if (sub_q == SUB_LAST) begin
            sh_d = sh_q >> 1;
            if (idx_q == idx_last) ph_d = PH_STOP;
            else                   idx_d = idx_q + IDX_ONE;
          end
        end
      end
      default: begin
        if (tick) begin
          sub_d = sub_q + SUB_ONE;
          if (sub_q == SUB_LAST) ph_d = PH_IDLE;
        end
      end
    endcase

    case (ph_d)
      PH_START: line_d = 1'b0;
      PH_DATA:  line_d = sh_d[0];
      default:  line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      nine_q <= 1'b0;
      line_q <= 1'b1;
    end else if (run) begin
      ph_q   <= ph_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      nine_q <= nine_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              nine,
  input  logic              line_in,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_ferr
);
  localparam logic [OSR_W-1:0] SUB_LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0] SUB_MID  = OSR_W'(OSR / 2 - 1);
  localparam logic [OSR_W-1:0] SUB_ONE  = OSR_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST9    = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST8    = IDX_W'(DATA_W - 2);

  logic               s1_q, s2_q, prev_q;
  phase_e             ph_q, ph_d;
  logic [OSR_W-1:0]   sub_q, sub_d;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_last;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               nine_q, nine_d;
  logic               ferr_q, ferr_d;
  logic               valid_q, valid_d;

  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign out_ferr  = ferr_q;
  assign idx_last  = nine_q ? LAST9 : LAST8;

  // two-flop synchronizer, always running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= line_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    ph_d    = ph_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    data_d  = data_q;
    nine_d  = nine_q;
    ferr_d  = ferr_q;
    valid_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (prev_q && !s2_q) begin
          ph_d  = PH_START;
          sub_d = '0;
        end
      end
      PH_START: begin
        if (tick) begin
          if (sub_q == SUB_MID) begin
            sub_d = '0;
            if (!s2_q) begin
              ph_d   = PH_DATA;
              idx_d  = '0;
              nine_d = nine;
            end else begin
              ph_d = PH_IDLE;
            end
          end else begin
            sub_d = sub_q + SUB_ONE;
          end
        end
      end
      PH_DATA: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d = '0;
            sh_d  = {s2_q, sh_q[DATA_W-1:1]};
            if (idx_q == idx_last) ph_d = PH_STOP;
            else                   idx_d = idx_q + IDX_ONE;
          end else begin
            sub_d = sub_q + SUB_ONE;
          end
        end
      end
      default: begin
        if (tick) begin
          if (sub_q == SUB_LAST) begin
            sub_d   = '0;
            ph_d    = PH_IDLE;
            valid_d = 1'b1;
            ferr_d  = !s2_q;
            data_d  = nine_q ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
          end else begin
            sub_d = sub_q + SUB_ONE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      ph_q   <= PH_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      nine_q <= 1'b0;
      ferr_q <= 1'b0;
    end else if (run) begin
      prev_q <= s2_q;
      ph_q   <= ph_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      data_q <= data_d;
      nine_q <= nine_d;
      ferr_q <= ferr_d;
    end
  end

  // strobe is not held by the freeze enable so it never stretches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end
endmodule

// File: rtl/sio_route.sv
module sio_route
  import sio_pkg::*;
(
  input  logic loop_sel,
  input  logic src_sel,
  input  logic tx_line,
  input  logic tx_busy,
  input  logic rxd,
  input  logic pad_in,
  output logic rx_line,
  output logic pad_out,
  output logic pad_oe
);
  route_e mode;

  always_comb begin
    if (!loop_sel)     mode = RT_NORMAL;
    else if (!src_sel) mode = RT_LOOP;
    else               mode = RT_SINGLE;

    case (mode)
      RT_LOOP:   rx_line = tx_line;
      RT_SINGLE: rx_line = pad_in;
      default:   rx_line = rxd;
    endcase

    pad_oe = (mode == RT_SINGLE) ? tx_busy : 1'b1;
  end

  assign pad_out = tx_line;
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr
  import sio_pkg::*;
#(
  parameter int unsigned DIV_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_loop,
  input  logic              cfg_rsel,
  input  logic              cfg_nine,
  input  logic              cfg_wfrz,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ferr,
  input  logic              rxd_i,
  input  logic              txd_pin_i,
  output logic              txd_o,
  output logic              txd_oe
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       run, tick, can_start;
  logic       tx_line, tx_busy, rx_line;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign run       = !(cfg_wfrz && wait_i);
  assign can_start = run && (cfg_div != '0);

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_int_n),
    .div   (cfg_div),
    .run   (run),
    .tick  (tick)
  );

  sio_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .can_start (can_start),
    .tick      (tick),
    .nine      (cfg_nine),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .in_ready  (tx_ready),
    .line      (tx_line),
    .busy      (tx_busy)
  );

  sio_route u_route (
    .loop_sel (cfg_loop),
    .src_sel  (cfg_rsel),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy),
    .rxd      (rxd_i),
    .pad_in   (txd_pin_i),
    .rx_line  (rx_line),
    .pad_out  (txd_o),
    .pad_oe   (txd_oe)
  );

  sio_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .tick      (tick),
    .nine      (cfg_nine),
    .line_in   (rx_line),
    .out_data  (rx_data),
    .out_valid (rx_valid),
    .out_ferr  (rx_ferr)
  );
endmodule

// File: rtl/sio_xcvr_chk.sv
module sio_xcvr_chk #(
  parameter int unsigned DIV_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_loop,
  input logic             cfg_rsel,
  input logic             cfg_nine,
  input logic             cfg_wfrz,
  input logic             wait_i,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_msb,
  input logic             rx_valid,
  input logic             txd_o,
  input logic             txd_oe
);
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd_o);

  p_div0_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_div == '0) |-> $stable(txd_o));

  p_div0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_div == '0) |-> !rx_valid);

  p_oe_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && cfg_rsel && tx_ready) |-> !txd_oe);

  p_oe_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_loop && cfg_rsel) |-> txd_oe);

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wfrz && wait_i) |-> ($stable(txd_o) && !rx_valid));

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_msb_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_nine) |-> !rx_msb);

  p_ready_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind sio_xcvr sio_xcvr_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_div  (cfg_div),
  .cfg_loop (cfg_loop),
  .cfg_rsel (cfg_rsel),
  .cfg_nine (cfg_nine),
  .cfg_wfrz (cfg_wfrz),
  .wait_i   (wait_i),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_msb   (rx_data[sio_pkg::DATA_W-1]),
  .rx_valid (rx_valid),
  .txd_o    (txd_o),
  .txd_oe   (txd_oe)
);

// File: tb/sim_sio_xcvr.sv
module sim_sio_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 13;
  localparam int WDOG       = 190000;

  logic             clk;
  logic             rst_n;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_loop, cfg_rsel, cfg_nine, cfg_wfrz, wait_i;
  logic [8:0]       tx_data;
  logic             tx_valid, tx_ready;
  logic [8:0]       rx_data;
  logic             rx_valid, rx_ferr;
  logic             rxd_b, pad_b;
  logic             txd_o, txd_oe;
  wire              pad = txd_oe ? txd_o : pad_b;

  int n_chk;
  int n_fail;
  bit done;

  sio_xcvr #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_loop(cfg_loop),
    .cfg_rsel(cfg_rsel), .cfg_nine(cfg_nine), .cfg_wfrz(cfg_wfrz), .wait_i(wait_i),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
    .rxd_i(rxd_b), .txd_pin_i(pad), .txd_o(txd_o), .txd_oe(txd_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(bit lp, bit rs, bit nn, int dv);
    @(negedge clk);
    cfg_loop = lp; cfg_rsel = rs; cfg_nine = nn; cfg_div = DIV_W'(dv);
    cyc(64 * (dv + 1));
  endtask

  task automatic send_tx(logic [8:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(int limit, output logic [8:0] d, output bit f, output bit got);
    got = 1'b0; d = '0; f = 1'b0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1'b1; d = rx_data; f = rx_ferr; end
    end
  endtask

  task automatic set_line(bit to_pad, logic v);
    if (to_pad) pad_b = v; else rxd_b = v;
  endtask

  task automatic drive_frame(bit to_pad, logic [8:0] d, int nb, logic stopv, int dv);
    set_line(to_pad, 1'b0); cyc(16 * dv);
    for (int i = 0; i < nb; i++) begin set_line(to_pad, d[i]); cyc(16 * dv); end
    set_line(to_pad, stopv); cyc(16 * dv);
    set_line(to_pad, 1'b1);
  endtask

  task automatic capture(int nb, int dv, output logic [8:0] d, output logic sb, output logic pb);
    d = '0;
    while (txd_o !== 1'b0) @(negedge clk);
    cyc(8 * dv - 1);
    sb = txd_o;
    for (int i = 0; i < nb; i++) begin cyc(16 * dv); d[i] = txd_o; end
    cyc(16 * dv);
    pb = txd_o;
  endtask

  task automatic low_len(output int n);
    while (txd_o !== 1'b0) @(negedge clk);
    while (txd_o !== 1'b1) @(negedge clk);
    while (txd_o !== 1'b0) @(negedge clk);
    n = 0;
    while (txd_o === 1'b0) begin n++; @(negedge clk); end
  endtask

  initial begin : wdog
    int c;
    c = 0;
    while (!done && c < WDOG) begin @(posedge clk); c++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", c);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] d;
    logic sb, pb;
    bit f, g, ok;
    int n, k;
    logic v;
    logic [8:0] vals9 [4];

    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_div = DIV_W'(1); cfg_loop = 0; cfg_rsel = 0; cfg_nine = 0;
    cfg_wfrz = 0; wait_i = 0; tx_data = '0; tx_valid = 0; rxd_b = 1; pad_b = 1;
    cyc(5);
    rst_n = 1'b1;
    cyc(8);

    // R1 reset state
    check(txd_o === 1'b1, "R1", "txd_o after reset", txd_o, 1);
    check(tx_ready === 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
    check(rx_valid === 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    check(txd_oe === 1'b1, "R1", "txd_oe after reset", txd_oe, 1);

    // R2 bit period for several divisors
    foreach (vals9[i]) vals9[i] = '0;
    for (int dv = 1; dv <= 5; dv += 2) begin
      setup(0, 0, 0, dv);
      fork
        send_tx(9'h055);
        low_len(n);
      join
      check(n == 16 * dv, "R2", "bit length in cycles", n, 16 * dv);
      cyc(200 * dv);
    end

    // R8 8-bit frame layout on the wire
    setup(0, 0, 0, 3);
    fork
      send_tx(9'h1B2);
      capture(8, 3, d, sb, pb);
    join
    check(sb === 1'b0, "R8", "start bit", sb, 0);
    check(d === 9'h0B2, "R8", "data bits lsb first", d, 9'h0B2);
    check(pb === 1'b1, "R8", "stop bit", pb, 1);
    cyc(300);

    // R4 normal reception from rxd_i
    setup(0, 0, 0, 1);
    ok = 1'b1;
    for (int i = 0; i < 256; i += 17) begin
      fork
        drive_frame(0, 9'(i), 8, 1'b1, 1);
        wait_rx(400, d, f, g);
      join
      check(g && d == 9'(i) && !f, "R4", "rxd_i frame", int'(d), i);
      cyc(20);
    end
    // R4 own transmission not received in two-pin mode
    send_tx(9'h00F);
    wait_rx(250, d, f, g);
    check(!g, "R4", "rx_valid from own tx", g, 0);

    // R11 framing error then clean frame
    cyc(100);
    fork
      drive_frame(0, 9'h05A, 8, 1'b0, 1);
      wait_rx(400, d, f, g);
    join
    check(g && d == 9'h05A, "R11", "data with bad stop", int'(d), 9'h05A);
    check(f === 1'b1, "R11", "rx_ferr on low stop", f, 1);
    cyc(64);
    fork
      drive_frame(0, 9'h033, 8, 1'b1, 1);
      wait_rx(400, d, f, g);
    join
    check(g && d == 9'h033 && f == 1'b0, "R11", "rx_ferr cleared", f, 0);

    // R7 rsel ignored in two-pin mode
    setup(0, 1, 0, 1);
    pad_b = 1'b0;
    check(txd_oe === 1'b1, "R7", "txd_oe with rsel=1", txd_oe, 1);
    fork
      drive_frame(0, 9'h0A5, 8, 1'b1, 1);
      wait_rx(400, d, f, g);
    join
    check(g && d == 9'h0A5, "R7", "rxd_i still used", int'(d), 9'h0A5);
    pad_b = 1'b1;

    // R5 internal loopback, exhaustive 8-bit sweep, rxd_i held low
    setup(1, 0, 0, 1);
    rxd_b = 1'b0;
    cyc(32);
    for (int i = 0; i < 256; i++) begin
      send_tx(9'h100 | 9'(i));
      wait_rx(300, d, f, g);
      check(g && d == 9'(i) && !f, "R5", "loopback word", int'(d), i);
      if (i == 0) begin
        @(negedge clk);
        check(rx_valid === 1'b0, "R12", "rx_valid width", rx_valid, 0);
      end
    end
    // R12 bit 8 zero in 8-bit mode (sent words had bit 8 set)
    check(d[8] === 1'b0, "R12", "rx_data[8] in 8-bit mode", d[8], 0);

    // R13 handshake
    cyc(40);
    send_tx(9'h0E1);
    check(tx_ready === 1'b0, "R13", "ready after accept", tx_ready, 0);
    cyc(100);
    check(tx_ready === 1'b0, "R13", "ready mid frame", tx_ready, 0);
    cyc(100);
    check(tx_ready === 1'b1, "R13", "ready after frame", tx_ready, 1);

    // R9 nine data bits
    setup(1, 0, 1, 2);
    vals9[0] = 9'h100; vals9[1] = 9'h1FF; vals9[2] = 9'h0AB; vals9[3] = 9'h155;
    for (int i = 0; i < 4; i++) begin
      send_tx(vals9[i]);
      wait_rx(800, d, f, g);
      check(g && d == vals9[i], "R9", "9-bit loop word", int'(d), int'(vals9[i]));
      cyc(80);
    end
    fork
      send_tx(9'h13A);
      capture(9, 2, d, sb, pb);
    join
    check(d === 9'h13A && sb === 1'b0 && pb === 1'b1, "R9", "9-bit wire frame", int'(d), 9'h13A);
    cyc(200);

    // R6 single-wire mode
    setup(1, 1, 0, 1);
    rxd_b = 1'b0;
    cyc(32);
    check(txd_oe === 1'b0, "R6", "oe released when idle", txd_oe, 0);
    send_tx(9'h03C);
    check(txd_oe === 1'b1, "R6", "oe during frame", txd_oe, 1);
    wait_rx(300, d, f, g);
    check(g && d == 9'h03C, "R6", "own frame via pad", int'(d), 9'h03C);
    cyc(60);
    check(txd_oe === 1'b0, "R6", "oe after frame", txd_oe, 0);
    fork
      drive_frame(1, 9'h0C3, 8, 1'b1, 1);
      wait_rx(400, d, f, g);
    join
    check(g && d == 9'h0C3, "R6", "external frame via pad", int'(d), 9'h0C3);
    rxd_b = 1'b1;

    // R3 zero divisor
    setup(1, 0, 0, 0);
    @(negedge clk);
    tx_data = 9'h042; tx_valid = 1'b1;
    g = 1'b0; ok = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (rx_valid) g = 1'b1;
      if (tx_ready !== 1'b0 || txd_o !== 1'b1) ok = 1'b0;
    end
    check(ok, "R3", "idle line and no ready with divisor 0", ok, 1);
    check(!g, "R3", "no reception with divisor 0", g, 0);
    cfg_div = DIV_W'(1);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_rx(300, d, f, g);
    check(g && d == 9'h042, "R3", "word sent after divisor set", int'(d), 9'h042);

    // R10 freeze in wait
    setup(1, 0, 0, 1);
    cfg_wfrz = 1'b1;
    send_tx(9'h096);
    cyc(40);
    wait_i = 1'b1;
    @(negedge clk);
    v = txd_o; ok = 1'b1; g = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd_o !== v) ok = 1'b0;
      if (rx_valid) g = 1'b1;
    end
    check(ok && !g, "R10", "frozen line and no strobe", ok, 1);
    wait_i = 1'b0;
    wait_rx(300, d, f, g);
    check(g && d == 9'h096, "R10", "frame after wait", int'(d), 9'h096);
    cyc(60);
    cfg_wfrz = 1'b0;
    wait_i = 1'b1;
    k = 0;
    send_tx(9'h069);
    wait_rx(300, d, f, g);
    check(g && d == 9'h069, "R10", "wait ignored when disabled", int'(d), 9'h069);
    wait_i = 1'b0;
    if (k != 0) n_chk++;

    cyc(20);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule